// File: doc/BRIEF.md
# Shared-Memory Doorbell Interrupt Registers

This block is the small register window of a node that shares memory with several other virtual machines. Software on the node uses it for two things: to see and acknowledge interrupts raised by its peers, and to ring a doorbell on a peer. The window is 256 bytes wide and is reached over a simple 32-bit register bus that only does whole-word accesses.

Four words are decoded. There is an interrupt enable word, an interrupt status word, a read-only word that reports this node's position number, and a write-only doorbell word. A doorbell write names a destination peer and a vector. The block checks both against a peer table that holds each peer's count of valid vectors and the highest peer number seen so far. Only writes that pass the check send a one-cycle notify pulse to the fabric that carries the event. Incoming events from the fabric OR bits into the status word. One level-sensitive interrupt line is raised while any enabled status bit is set.

Top module: `shdb_regs`

## Requirements
- R1: Word decode uses the address ANDed with 0xFC. The enable word is at 0x0, status at 0x4, position at 0x8 and doorbell at 0xC. The enable and status words read back their stored value, the doorbell word reads as zero, and any other offset in the window reads as zero.
- R2: `irq` is high exactly when the bitwise AND of status and enable is non-zero. It follows every change of either word on the clock edge that makes the change.
- R3: A status read returns the current value on `bus_rdata` during the access and leaves status at zero after that edge.
- R4: A status write replaces all 32 bits with the write data. It is not write-one-to-clear.
- R5: When `evt_valid` is high, `evt_bits` (8 bits) is ORed into status bits 7:0. If an event coincides with a status read or a status write, the event bits are still set after the edge.
- R6: A doorbell write carries the destination peer in data bits 31:16 and the vector in bits 7:0. Bits 15:8 are ignored. A write that passes the checks gives `notify_valid` high for exactly the one cycle after the write edge, with `notify_peer` and `notify_vector` equal to the decoded fields.
- R7: A doorbell write whose destination is greater than the highest known peer number gives no pulse.
- R8: A doorbell write whose vector is not below the destination's vector count gives no pulse. Loading a count of zero removes all vectors of that peer.
- R9: A position read returns `node_pos`, zero-extended, while `shm_mapped` is high, and 0xFFFFFFFF while it is low.
- R10: Address bits 1:0 are ignored. Writes to the position word or to undefined offsets change no readable state and give no pulse.
- R11: After reset, status, enable, every vector count and the highest peer number are zero. `irq` and `notify_valid` are low.
- R12: `tbl_load` writes `tbl_count` into the entry for `tbl_peer`, with a 4-bit index and 16 entries. A non-zero count raises the highest known peer number to `tbl_peer` if that is larger. The highest known peer number never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational during the access |
| node_pos | input | 16 | This node's position number |
| shm_mapped | input | 1 | Shared memory is mapped |
| tbl_load | input | 1 | Load one peer-table entry |
| tbl_peer | input | 4 | Peer index to load |
| tbl_count | input | 8 | Vector count for that peer, 0 = absent |
| evt_valid | input | 1 | Incoming event strobe |
| evt_bits | input | 8 | Bits to OR into status |
| irq | output | 1 | Level interrupt |
| notify_valid | output | 1 | One-cycle doorbell notify |
| notify_peer | output | 16 | Destination peer of the notify |
| notify_vector | output | 8 | Vector of the notify |

## Verification
The doorbell path is driven with destinations below, equal to and above the highest known peer, and with vectors just below and exactly at the count. This separates the two drop conditions from a valid ring. Bits 15:8 of the data are filled with noise so that a decoder which leaks them shows up. Status reads are tried alone, together with an event and together with a write, which separates a plain clear, a clear that loses event bits, and a write-one-to-clear implementation. A random mix of enable, status, event, table and doorbell traffic is compared against a bench model of the interrupt level and the notify pulse after every operation.

// File: rtl/shdb_pkg.sv
package shdb_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int PEER_FIELD_W = 16;
  localparam int VEC_FIELD_W = 8;
  localparam int EVT_W = 8;

  // word indices after the address is ANDed with 0xFC
  typedef enum logic [5:0] {
    W_ENABLE   = 6'd0,
    W_STATUS   = 6'd1,
    W_POSITION = 6'd2,
    W_DOORBELL = 6'd3
  } word_e;

  function automatic logic [5:0] word_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] m;
    m = a & 8'hFC;
    return m[7:2];
  endfunction

  function automatic logic [PEER_FIELD_W-1:0] bell_dest(input logic [DATA_W-1:0] d);
    return d[31:16];
  endfunction

  function automatic logic [VEC_FIELD_W-1:0] bell_vec(input logic [DATA_W-1:0] d);
    return d[7:0];
  endfunction

  function automatic logic [DATA_W-1:0] status_next(
    input logic [DATA_W-1:0] cur, input logic rd_clr, input logic wr,
    input logic [DATA_W-1:0] wd, input logic ev, input logic [EVT_W-1:0] eb);
    logic [DATA_W-1:0] base;
    if (wr) base = wd;
    else if (rd_clr) base = '0;
    else base = cur;
    return base | (ev ? {{(DATA_W-EVT_W){1'b0}}, eb} : '0);
  endfunction
endpackage

// File: rtl/shdb_peer_table.sv
module shdb_peer_table #(
  parameter int NUM_PEERS = 16,
  parameter int CNT_W = 8,
  localparam int IDX_W = $clog2(NUM_PEERS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld,
  input  logic [IDX_W-1:0]     ld_peer,
  input  logic [CNT_W-1:0]     ld_count,
  input  logic [15:0]          look_peer,
  output logic [CNT_W-1:0]     look_count,
  output logic [IDX_W-1:0]     max_peer
);
  logic [CNT_W-1:0] cnt_q [NUM_PEERS];

  for (genvar g = 0; g < NUM_PEERS; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q[g] <= '0;
      else if (ld && ld_peer == IDX_W'(g)) cnt_q[g] <= ld_count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) max_peer <= '0;
    else if (ld && ld_count != '0 && ld_peer > max_peer) max_peer <= ld_peer;
  end

  always_comb begin
    look_count = '0;
    if (look_peer < 16'(NUM_PEERS)) look_count = cnt_q[look_peer[IDX_W-1:0]];
  end
endmodule

// File: rtl/shdb_bell_gate.sv
module shdb_bell_gate
  import shdb_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int CNT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ring,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [IDX_W-1:0]         max_peer,
  input  logic [CNT_W-1:0]         dest_count,
  output logic                     bell_ok,
  output logic                     notify_valid,
  output logic [PEER_FIELD_W-1:0]  notify_peer,
  output logic [VEC_FIELD_W-1:0]   notify_vector
);
  logic dest_ok, vec_ok;

  assign dest_ok = bell_dest(wdata) <= PEER_FIELD_W'(max_peer);
  assign vec_ok  = CNT_W'(bell_vec(wdata)) < dest_count;
  assign bell_ok = ring && dest_ok && vec_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      notify_valid  <= 1'b0;
      notify_peer   <= '0;
      notify_vector <= '0;
    end else begin
      notify_valid <= bell_ok;
      if (bell_ok) begin
        notify_peer   <= bell_dest(wdata);
        notify_vector <= bell_vec(wdata);
      end
    end
  end
endmodule

// File: rtl/shdb_irq_core.sv
module shdb_irq_core
  import shdb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_we,
  input  logic              status_we,
  input  logic              status_rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ev_valid,
  input  logic [EVT_W-1:0]  ev_bits,
  output logic [DATA_W-1:0] enable_q,
  output logic [DATA_W-1:0] status_q,
  output logic              irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      status_q <= '0;
    end else begin
      if (enable_we) enable_q <= wdata;
      status_q <= status_next(status_q, status_rd, status_we, wdata, ev_valid, ev_bits);
    end
  end

  assign irq = |(status_q & enable_q);
endmodule

// File: rtl/shdb_regs.sv
module shdb_regs
  import shdb_pkg::*;
#(
  parameter int NUM_PEERS = 16,
  parameter int CNT_W = 8,
  localparam int IDX_W = $clog2(NUM_PEERS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [15:0]        node_pos,
  input  logic               shm_mapped,
  input  logic               tbl_load,
  input  logic [3:0]         tbl_peer,
  input  logic [7:0]         tbl_count,
  input  logic               evt_valid,
  input  logic [7:0]         evt_bits,
  output logic               irq,
  output logic               notify_valid,
  output logic [15:0]        notify_peer,
  output logic [7:0]         notify_vector
);
  logic [5:0]        word;
  logic              wr_enable, wr_status, rd_status, wr_bell;
  logic [31:0]       enable_q, status_q;
  logic [IDX_W-1:0]  max_peer_q;
  logic [CNT_W-1:0]  dest_count;
  logic              bell_ok;

  assign word      = word_of(bus_addr);
  assign wr_enable = bus_sel &&  bus_wr && word == W_ENABLE;
  assign wr_status = bus_sel &&  bus_wr && word == W_STATUS;
  assign rd_status = bus_sel && !bus_wr && word == W_STATUS;
  assign wr_bell   = bus_sel &&  bus_wr && word == W_DOORBELL;

  shdb_irq_core u_irq (
    .clk(clk), .rst_n(rst_n),
    .enable_we(wr_enable), .status_we(wr_status), .status_rd(rd_status),
    .wdata(bus_wdata), .ev_valid(evt_valid), .ev_bits(evt_bits),
    .enable_q(enable_q), .status_q(status_q), .irq(irq)
  );

  shdb_peer_table #(.NUM_PEERS(NUM_PEERS), .CNT_W(CNT_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .ld(tbl_load), .ld_peer(tbl_peer[IDX_W-1:0]), .ld_count(tbl_count[CNT_W-1:0]),
    .look_peer(bell_dest(bus_wdata)), .look_count(dest_count), .max_peer(max_peer_q)
  );

  shdb_bell_gate #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_bell (
    .clk(clk), .rst_n(rst_n),
    .ring(wr_bell), .wdata(bus_wdata), .max_peer(max_peer_q), .dest_count(dest_count),
    .bell_ok(bell_ok), .notify_valid(notify_valid),
    .notify_peer(notify_peer), .notify_vector(notify_vector)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (word)
        W_ENABLE:   bus_rdata = enable_q;
        W_STATUS:   bus_rdata = status_q;
        W_POSITION: bus_rdata = shm_mapped ? {16'h0, node_pos} : 32'hFFFF_FFFF;
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/shdb_checker.sv
module shdb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        shm_mapped,
  input logic        evt_valid,
  input logic [7:0]  evt_bits,
  input logic        irq,
  input logic        notify_valid,
  input logic [31:0] enable_q,
  input logic [31:0] status_q,
  input logic [3:0]  max_peer_q
);
  logic rd_st, wr_db;
  assign rd_st = bus_sel && !bus_wr && bus_addr[7:2] == 6'd1;
  assign wr_db = bus_sel &&  bus_wr && bus_addr[7:2] == 6'd3;

  p_no_irq_unmasked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == 32'h0) |-> !irq);

  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_st && !evt_valid && !bus_wr) |=> (status_q == 32'h0));

  p_event_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> ((status_q[7:0] & $past(evt_bits)) == $past(evt_bits)));

  p_pulse_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> $past(wr_db));

  p_far_dest_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_db && bus_wdata[31:16] > {12'h0, max_peer_q}) |=> !notify_valid);

  p_unmapped_pos_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[7:2] == 6'd2 && !shm_mapped) |-> (bus_rdata == 32'hFFFF_FFFF));

  p_max_peer_monotonic_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (max_peer_q >= $past(max_peer_q)));
endmodule

bind shdb_regs shdb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .shm_mapped(shm_mapped),
  .evt_valid(evt_valid), .evt_bits(evt_bits), .irq(irq), .notify_valid(notify_valid),
  .enable_q(enable_q), .status_q(status_q), .max_peer_q(max_peer_q)
);

// File: tb/sim_shdb_regs.sv
module sim_shdb_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [15:0] node_pos = 16'h002A;
  logic shm_mapped = 0;
  logic tbl_load = 0;
  logic [3:0] tbl_peer = 0;
  logic [7:0] tbl_count = 0;
  logic evt_valid = 0;
  logic [7:0] evt_bits = 0;
  logic irq, notify_valid;
  logic [15:0] notify_peer;
  logic [7:0] notify_vector;

  int errors = 0, checks = 0;
  bit done = 0;

  // bench model
  logic [31:0] m_en, m_st;
  logic [7:0] m_cnt [16];
  int m_max;

  always #(CLK_PERIOD/2) clk = ~clk;

  shdb_regs u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit bell_passes(input logic [31:0] d);
    int dst = int'(d[31:16]);
    if (dst > m_max) return 0;
    return {24'h0, d[7:0]} < {24'h0, m_cnt[dst]};
  endfunction

  function automatic logic exp_irq();
    return (m_st & m_en) != 0;
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input string req);
    bit ring, pass;
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    ring = (a[7:2] == 6'd3);
    pass = ring && bell_passes(d);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    case (a[7:2])
      6'd0: m_en = d;
      6'd1: m_st = d;
      default: ;
    endcase
    chk({req, " notify"}, {31'h0, notify_valid}, {31'h0, pass});
    if (pass) begin
      chk({req, " R6 peer"}, {16'h0, notify_peer}, {16'h0, d[31:16]});
      chk({req, " R6 vector"}, {24'h0, notify_vector}, {24'h0, d[7:0]});
    end
    chk({req, " R2 irq"}, {31'h0, irq}, {31'h0, exp_irq()});
    @(negedge clk);
    if (pass) chk("R6 pulse one cycle", {31'h0, notify_valid}, 32'h0);
  endtask

  task automatic bus_read(input logic [7:0] a, input logic ev, input logic [7:0] eb,
                          output logic [31:0] val);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a; evt_valid = ev; evt_bits = eb;
    #1 val = bus_rdata;
    @(negedge clk);
    bus_sel = 0; evt_valid = 0;
    if (a[7:2] == 6'd1) m_st = 0;
    if (ev) m_st = m_st | {24'h0, eb};
  endtask

  task automatic event_in(input logic [7:0] eb);
    @(negedge clk);
    evt_valid = 1; evt_bits = eb;
    @(negedge clk);
    evt_valid = 0;
    m_st = m_st | {24'h0, eb};
    chk("R5 event irq", {31'h0, irq}, {31'h0, exp_irq()});
  endtask

  task automatic load_peer(input logic [3:0] p, input logic [7:0] c);
    @(negedge clk);
    tbl_load = 1; tbl_peer = p; tbl_count = c;
    @(negedge clk);
    tbl_load = 0;
    m_cnt[p] = c;
    if (c != 0 && int'(p) > m_max) m_max = int'(p);
  endtask

  task automatic check_regs(input string req);
    logic [31:0] v;
    bus_read(8'h00, 0, 0, v);
    chk({req, " enable"}, v, m_en);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    m_en = 0; m_st = 0; m_max = 0;
    for (int i = 0; i < 16; i++) m_cnt[i] = 0;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R11 reset state
    chk("R11 irq", {31'h0, irq}, 0);
    chk("R11 notify", {31'h0, notify_valid}, 0);
    rst_n = 1;
    bus_read(8'h00, 0, 0, v); chk("R11 enable", v, 0);
    bus_read(8'h04, 0, 0, v); chk("R11 status", v, 0);
    // R11/R8 peer 0 has no vectors after reset
    bus_write(8'h0C, 32'h0000_0000, "R11 empty table");

    // R9 position word
    bus_read(8'h08, 0, 0, v); chk("R9 unmapped", v, 32'hFFFF_FFFF);
    shm_mapped = 1;
    bus_read(8'h08, 0, 0, v); chk("R9 mapped", v, 32'h0000_002A);
    bus_read(8'h0B, 0, 0, v); chk("R10 low bits ignored on read", v, 32'h0000_002A);

    // R1 undefined offsets and doorbell read as zero
    bus_write(8'h00, 32'hA5A5_0F0F, "R1 enable write");
    bus_read(8'h00, 0, 0, v); chk("R1 enable readback", v, 32'hA5A5_0F0F);
    bus_read(8'h0C, 0, 0, v); chk("R1 doorbell reads zero", v, 0);
    bus_read(8'h40, 0, 0, v); chk("R1 undefined reads zero", v, 0);

    // R4 status write replaces, R2 irq follows, R3 read clears
    bus_write(8'h04, 32'h0000_00F0, "R4 write");
    bus_write(8'h04, 32'h0000_0001, "R4 replace");
    bus_read(8'h04, 0, 0, v); chk("R4 replaced not w1c", v, 32'h0000_0001);
    chk("R3 cleared irq", {31'h0, irq}, 0);
    bus_read(8'h04, 0, 0, v); chk("R3 status zero after read", v, 0);

    // R5 event, and event colliding with a read and with a write
    event_in(8'h03);
    bus_read(8'h04, 1, 8'h40, v); chk("R5 read value", v, 32'h3);
    bus_read(8'h04, 0, 0, v); chk("R5 event survives read", v, 32'h40);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h04; bus_wdata = 32'h100; evt_valid = 1; evt_bits = 8'h08;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; evt_valid = 0; m_st = 32'h108;
    bus_read(8'h04, 0, 0, v); chk("R5 event survives write", v, 32'h108);

    // R10 writes to position and undefined words have no effect
    bus_write(8'h08, 32'hFFFF_FFFF, "R10 position write");
    bus_write(8'h80, 32'hFFFF_FFFF, "R10 undefined write");
    bus_read(8'h08, 0, 0, v); chk("R10 position unchanged", v, 32'h2A);
    bus_read(8'h04, 0, 0, v); chk("R10 status unchanged", v, 0);
    check_regs("R10");
    bus_write(8'h05, 32'h0000_0004, "R10 unaligned status write");
    bus_read(8'h04, 0, 0, v); chk("R10 unaligned lands on status", v, 32'h4);

    // R12 table and R7/R8 doorbell limits
    load_peer(4'd3, 8'd2);
    load_peer(4'd1, 8'd5);
    bus_write(8'h0C, 32'h0003_AB01, "R6 valid ring with noise in 15:8");
    bus_write(8'h0C, 32'h0003_0002, "R8 vector equal to count");
    bus_write(8'h0C, 32'h0004_0000, "R7 dest above max");
    bus_write(8'h0C, 32'h0001_0004, "R6 ring peer 1 top vector");
    bus_write(8'h0C, 32'h0002_0000, "R8 absent peer below max");
    load_peer(4'd3, 8'd0);
    bus_write(8'h0C, 32'h0003_0000, "R8 removed peer");
    bus_write(8'h0C, 32'h0001_0000, "R12 max kept after removal");
    bus_write(8'h0F, 32'h0001_0003, "R10 unaligned doorbell");

    // random mix against the model
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 5);
      case (op)
        0: bus_write(8'h00, $urandom & 32'h0000_00FF, "R2 rand enable");
        1: bus_write(8'h04, $urandom & 32'h0000_0FFF, "R4 rand status");
        2: begin
          logic [31:0] exp_v = m_st;
          logic e = 1'($urandom_range(0, 1));
          logic [7:0] b = 8'($urandom);
          bus_read(8'h04, e, b, v);
          chk("R3 rand read", v, exp_v);
        end
        3: event_in(8'($urandom));
        4: load_peer(4'($urandom), 8'($urandom_range(0, 4)));
        default: bus_write(8'h0C, {16'($urandom_range(0, 17)), 8'($urandom), 8'($urandom_range(0, 5))},
                           "R7 R8 rand doorbell");
      endcase
    end
    bus_read(8'h04, 0, 0, v); chk("R3 final status", v, m_st);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule